// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for each beat of one SDRAM burst. A read or write command upstream loads a start column and a burst length code. From the next clock on, the block presents one column per clock until the burst is complete, or until a terminate strobe or a fresh load ends it.

Fixed-length bursts of 2, 4 and 8 beats count upward from the start offset. They wrap inside the naturally aligned block that holds the start column, so the column bits above the block never change. A burst length of one gives only the start column. Full-page mode counts across the whole row, rolls from the top column to zero, and does not stop until it is terminated or reloaded.

An advance enable freezes the sequence for clock suspend. A new load may arrive on any clock, including in the middle of a burst, and it restarts the sequence at once.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `colValid` and `colLast` are 0 and `colOut` is 0.
- R2: When `loadEn` is sampled high, `colOut` equals `startCol` and `colValid` is 1 in the following cycle. This holds even when a burst is running or `termEn` is high in the same cycle.
- R3: `lenCode` selects the burst length. 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 behave as length 1.
- R4: Each advancing beat of a fixed burst of length L increments the low log2(L) bits of the column modulo L and leaves the upper bits unchanged. For example, length 4 from offset 2 gives offsets 2,3,0,1.
- R5: `colLast` is 1 exactly on the final beat of a fixed burst. An advance on that beat drops `colValid` to 0.
- R6: In full-page mode the column increments modulo 2^COL_W, so the top column is followed by 0. `colLast` is never 1, and the burst continues until it is terminated or reloaded.
- R7: While `advEn` is 0 the column, `colValid`, and the count of remaining beats are all held.
- R8: `termEn` without `loadEn` drops `colValid` and `colLast` to 0 in the next cycle.
- R9: Loads on consecutive clocks are each accepted, and each one restarts the sequence at its own start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Start a burst from startCol |
| startCol | input | COL_W | First column of the burst |
| lenCode | input | 3 | Burst length code |
| advEn | input | 1 | Advance one beat (low during clock suspend) |
| termEn | input | 1 | End the current burst |
| colOut | output | COL_W | Current column |
| colValid | output | 1 | A burst beat is presented |
| colLast | output | 1 | Final beat of a fixed-length burst |

## Verification
A corrupted remaining-beat count appears on the ports as `colLast` rising on the wrong beat, or as `colValid` staying high past the end of the burst. It becomes visible at the latest on the eighth beat after the load. A wrong wrap mask becomes visible on the first beat that crosses the block boundary: the upper column bits change, or full-page mode raises `colLast`. A missed restart or terminate shows up in the very next cycle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int LEN_W = 3;
  localparam int CNT_W = 3;
  localparam logic [LEN_W-1:0] LEN_FULL = 3'd7;

  typedef struct packed {
    logic load;
    logic step;
  } colCtl_t;

  function automatic logic [CNT_W-1:0] beatsAfterFirst(input logic [LEN_W-1:0] code);
    case (code)
      3'd1: beatsAfterFirst = 3'd1;
      3'd2: beatsAfterFirst = 3'd3;
      3'd3: beatsAfterFirst = 3'd7;
      default: beatsAfterFirst = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             advEn,
  input  logic             termEn,
  output colCtl_t          ctl,
  output logic             validQ,
  output logic             lastQ
);
  logic             fullQ;
  logic [CNT_W-1:0] leftQ;

  assign lastQ    = validQ && !fullQ && (leftQ == '0);
  assign ctl.load = loadEn;
  assign ctl.step = validQ && advEn && !lastQ && !loadEn && !termEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      fullQ  <= 1'b0;
      leftQ  <= '0;
    end else if (loadEn) begin
      validQ <= 1'b1;
      fullQ  <= (lenCode == LEN_FULL);
      leftQ  <= beatsAfterFirst(lenCode);
    end else if (termEn) begin
      validQ <= 1'b0;
    end else if (validQ && advEn) begin
      if (lastQ) validQ <= 1'b0;
      else if (!fullQ) leftQ <= leftQ - 1'b1;
    end
  end
endmodule

// File: rtl/colgen_dpath.sv
module colgen_dpath
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colCtl_t          ctl,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  output logic [COL_W-1:0] colQ
);
  localparam int BLK_MAX = 3;
  logic [COL_W-1:0] maskQ, maskNew, colInc, colNext;

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    if (i < BLK_MAX) begin : g_low
      assign maskNew[i] = (lenCode == LEN_FULL) ||
                          ((lenCode <= 3'd3) && (lenCode > LEN_W'(i)));
    end else begin : g_high
      assign maskNew[i] = (lenCode == LEN_FULL);
    end
  end

  assign colInc  = colQ + 1'b1;
  assign colNext = (colQ & ~maskQ) | (colInc & maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ  <= '0;
      maskQ <= '0;
    end else if (ctl.load) begin
      colQ  <= startCol;
      maskQ <= maskNew;
    end else if (ctl.step) begin
      colQ  <= colNext;
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             advEn,
  input  logic             termEn,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             colLast
);
  colCtl_t ctl;

  colgen_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .lenCode(lenCode),
    .advEn(advEn), .termEn(termEn), .ctl(ctl),
    .validQ(colValid), .lastQ(colLast)
  );

  colgen_dpath #(.COL_W(COL_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startCol(startCol),
    .lenCode(lenCode), .colQ(colOut)
  );
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadEn,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       lenCode,
  input logic             advEn,
  input logic             termEn,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             colLast
);
  logic             ckFull;
  logic [COL_W-1:0] ckMask;
  logic             stepping;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckFull <= 1'b0;
      ckMask <= '0;
    end else if (loadEn) begin
      ckFull <= (lenCode == 3'd7);
      if (lenCode == 3'd7) ckMask <= '1;
      else if (lenCode <= 3'd3) ckMask <= COL_W'((1 << lenCode) - 1);
      else ckMask <= '0;
    end
  end

  assign stepping = colValid && advEn && !colLast && !loadEn && !termEn;

  AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> colValid && colOut == $past(startCol)); // R2
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid); // R5
  AST_LAST_ADV_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    colLast && advEn && !loadEn && !termEn |=> !colValid); // R5
  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    ckFull |-> !colLast); // R6
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    colValid && !advEn && !loadEn && !termEn |=> colValid && $stable(colOut)); // R7
  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    termEn && !loadEn |=> !colValid && !colLast); // R8
  AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    stepping |=> ((colOut & ~ckMask) == ($past(colOut) & ~ckMask)) &&
                 ((colOut & ckMask) == (($past(colOut) + 1'b1) & ckMask))); // R4
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) uChk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .startCol(startCol),
  .lenCode(lenCode), .advEn(advEn), .termEn(termEn), .colOut(colOut),
  .colValid(colValid), .colLast(colLast)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  localparam int COL_W = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0, advEn = 1'b0, termEn = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic [COL_W-1:0] colOut;
  logic colValid, colLast;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .startCol(startCol),
    .lenCode(lenCode), .advEn(advEn), .termEn(termEn), .colOut(colOut),
    .colValid(colValid), .colLast(colLast)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadBurst(input logic [2:0] code, input logic [COL_W-1:0] sc);
    loadEn = 1'b1; lenCode = code; startCol = sc; advEn = 1'b1; termEn = 1'b0;
    tick();
    loadEn = 1'b0;
  endtask

  function automatic logic [COL_W-1:0] expCol(input logic [COL_W-1:0] sc, input int n, input int i);
    logic [COL_W-1:0] m = COL_W'(n - 1);
    return (sc & ~m) | (COL_W'(sc + i) & m);
  endfunction

  task automatic tReset();
    chk("R1 valid", colValid, 0);
    chk("R1 last", colLast, 0);
    chk("R1 col", colOut, 0);
  endtask

  task automatic tFixed(input logic [2:0] code, input int n, input logic [COL_W-1:0] sc);
    loadBurst(code, sc);
    for (int i = 0; i < n; i++) begin
      chk("R2/R4 col", colOut, expCol(sc, n, i));
      chk("R3 valid", colValid, 1);
      chk("R5 last", colLast, (i == n - 1) ? 1 : 0);
      tick();
    end
    chk("R5 end valid", colValid, 0);
  endtask

  task automatic tFullPage();
    loadBurst(3'd7, 8'hFD);
    for (int i = 0; i < 6; i++) begin
      chk("R6 col", colOut, (8'hFD + i) % 256);
      chk("R6 last", colLast, 0);
      tick();
    end
    chk("R6 still valid", colValid, 1);
    termEn = 1'b1; tick(); termEn = 1'b0;
    chk("R8 valid after term", colValid, 0);
  endtask

  task automatic tSuspend();
    logic [COL_W-1:0] sc = 8'h2D;
    loadBurst(3'd3, sc);
    tick();
    chk("R7 pre", colOut, 8'h2E);
    advEn = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7 hold col", colOut, 8'h2E);
      chk("R7 hold valid", colValid, 1);
    end
    advEn = 1'b1;
    for (int i = 2; i < 8; i++) begin
      tick();
      chk("R7 resume col", colOut, expCol(sc, 8, i));
      chk("R7 last count kept", colLast, (i == 7) ? 1 : 0);
    end
    tick();
    chk("R7 end", colValid, 0);
  endtask

  task automatic tTerminate();
    loadBurst(3'd3, 8'h10);
    tick();
    termEn = 1'b1; tick(); termEn = 1'b0;
    chk("R8 valid", colValid, 0);
    chk("R8 last", colLast, 0);
    loadBurst(3'd2, 8'h20);
    termEn = 1'b1; loadEn = 1'b1; startCol = 8'h57; lenCode = 3'd1;
    tick();
    termEn = 1'b0; loadEn = 1'b0;
    chk("R2 load beats term col", colOut, 8'h57);
    chk("R2 load beats term valid", colValid, 1);
    tick();
    chk("R2 second beat", colOut, 8'h56);
    chk("R5 second beat last", colLast, 1);
    tick();
  endtask

  task automatic tRestart();
    loadBurst(3'd2, 8'h42);
    tick();
    chk("R9 mid", colOut, 8'h43);
    loadBurst(3'd1, 8'h91);
    chk("R9 restart col", colOut, 8'h91);
    chk("R9 restart last", colLast, 0);
    tick();
    chk("R9 wrap col", colOut, 8'h90);
    chk("R9 wrap last", colLast, 1);
    tick();
    loadEn = 1'b1; lenCode = 3'd3; advEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      startCol = COL_W'(8'hA0 + 8'h11 * i);
      tick();
      chk("R9 back-to-back", colOut, 8'hA0 + 8'h11 * i);
    end
    loadEn = 1'b0;
    termEn = 1'b1; tick(); termEn = 1'b0;
  endtask

  task automatic tReserved();
    loadBurst(3'd5, 8'h77);
    chk("R3 reserved col", colOut, 8'h77);
    chk("R3 reserved last", colLast, 1);
    tick();
    chk("R3 reserved end", colValid, 0);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(); tick();
    tReset();
    rstN = 1'b1;
    tick();
    tReset();
    tFixed(3'd0, 1, 8'h35);
    tFixed(3'd1, 2, 8'h35);
    tFixed(3'd2, 4, 8'h12);
    tFixed(3'd3, 8, 8'h6B);
    tFullPage();
    tSuspend();
    tTerminate();
    tRestart();
    tReserved();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule